// File: doc/BRIEF.md
# Command-Driven Event Counter Bank

This block watches a set of signal vectors and keeps one counter for each of them. For every channel a change detector compares the vector with the value it held one cycle earlier. It raises an activity flag in any cycle where at least one bit differs. The counter for that channel adds one for each flagged cycle, but only while its controller is in the counting state. Vectors of one bit go through the same detector, so every channel behaves alike.

Each channel's controller takes 2-bit commands, sent to one channel at a time through an address port. A command can start counting, clear the counter, or freeze it so it can be read. The monitor output is a registered selection of the addressed counter. A global reset puts every channel back into the cleared state at once.

Top module: `evmon_bank`

## Requirements
- R1: After the global reset, every counter reads zero and stays in the cleared state. Activity on the watched vectors does not raise the count until a start command arrives.
- R2: Command code 01, sent to a channel, moves it to the counting state at that clock edge. From the next edge on, the counter adds one at every edge where its activity flag is 1.
- R3: Command code 10 moves the addressed channel to the cleared state. Its counter becomes zero and stays zero whatever its vector does.
- R4: Command code 11 moves the addressed channel to the frozen state. Its counter keeps its value while the vector keeps changing.
- R5: Command code 00 changes nothing. A channel whose index differs from the address port keeps its state and value, whatever command is present.
- R6: The activity flag is 1 in a cycle where the vector differs from its value one cycle earlier, and 0 when it is unchanged. A vector that inverts every cycle therefore counts every cycle, and a constant vector counts nothing.
- R7: The counter wraps modulo 2 to the power of the counter width, with no saturation.
- R8: The monitor output at a clock edge takes the value that the counter at the address present before that edge held before that edge. The value is therefore visible one cycle after the address is applied.
- R9: The global reset overrides any command applied in the same cycle. A channel addressed with a start command during reset is still cleared afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high global reset |
| cmd_addr | input | ADDR_W | Index of the channel that receives the command and is shown on the output |
| cmd | input | 2 | Command code: 00 none, 01 count, 10 clear, 11 freeze |
| watch_bus | input | NUM_CH*VEC_W | Watched vectors; channel i occupies bits i*VEC_W upward |
| mon_out | output | CNT_W | Registered value of the addressed counter |

## Verification
If a controller state is wrong, the read value drifts. An idle or cleared channel that wrongly counts, or a counting one that misses a flag, shows at the output on the first read after the faulty edge. The output register adds one cycle. The bench models every channel and compares the output on every cycle while it sweeps all addresses and commands. A fault in the change detector or the decoder therefore shows within one or two cycles of the stimulus that triggers it. A small counter width brings wrap-around within reach.

// File: rtl/evmon_pkg.sv
package evmon_pkg;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'b00,
    CMD_RUN  = 2'b01,
    CMD_CLR  = 2'b10,
    CMD_HOLD = 2'b11
  } cmd_t;

  typedef enum logic [1:0] {
    ST_RESET = 2'd0,
    ST_COUNT = 2'd1,
    ST_IDLE  = 2'd2
  } st_t;

  function automatic st_t next_state(st_t cur, cmd_t c);
    case (c)
      CMD_RUN:  return ST_COUNT;
      CMD_CLR:  return ST_RESET;
      CMD_HOLD: return ST_IDLE;
      default:  return cur;
    endcase
  endfunction

endpackage

// File: rtl/evmon_chg_det.sv
module evmon_chg_det #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VEC_W-1:0] vec_in,
  output logic             act
);
  logic [VEC_W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= vec_in;
  end

  assign act = |(vec_in ^ prev_q);
endmodule

// File: rtl/evmon_cnt_unit.sv
module evmon_cnt_unit
  import evmon_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  cmd_t             cmd_in,
  input  logic             act,
  output logic [CNT_W-1:0] cnt_out
);
  st_t              st_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] count_next(st_t s, logic [CNT_W-1:0] c, logic a);
    case (s)
      ST_RESET: return '0;
      ST_COUNT: return c + CNT_W'(a);
      default:  return c;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_RESET;
      cnt_q <= '0;
    end else begin
      st_q  <= next_state(st_q, cmd_in);
      cnt_q <= count_next(st_q, cnt_q, act);
    end
  end

  assign cnt_out = cnt_q;

  assert_clear_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RESET) |=> (cnt_q == '0));
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE) |=> $stable(cnt_q));
  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_COUNT) |=> (cnt_q == CNT_W'($past(cnt_q) + CNT_W'($past(act)))));
  assert_nop_keeps_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_in == CMD_NOP) |=> (st_q == $past(st_q)));
endmodule

// File: rtl/evmon_out_mux.sv
module evmon_out_mux #(
  parameter int NUM_CH = 16,
  parameter int CNT_W  = 32,
  localparam int ADDR_W = $clog2(NUM_CH)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [NUM_CH*CNT_W-1:0] cnt_flat,
  output logic [CNT_W-1:0]        mon_q
);
  logic [CNT_W-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (addr == ADDR_W'(i)) pick = cnt_flat[i*CNT_W +: CNT_W];
  end

  always_ff @(posedge clk) begin
    if (rst) mon_q <= '0;
    else     mon_q <= pick;
  end
endmodule

// File: rtl/evmon_bank.sv
module evmon_bank
  import evmon_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int VEC_W  = 8,
  parameter int CNT_W  = 32,
  localparam int ADDR_W = $clog2(NUM_CH)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       cmd_addr,
  input  logic [1:0]              cmd,
  input  logic [NUM_CH*VEC_W-1:0] watch_bus,
  output logic [CNT_W-1:0]        mon_out
);
  cmd_t                    cmd_c;
  logic [NUM_CH-1:0]       sel_vec;
  logic [NUM_CH-1:0]       act_vec;
  logic [NUM_CH*CNT_W-1:0] cnt_flat;

  assign cmd_c = cmd_t'(cmd);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    cmd_t ch_cmd;
    assign sel_vec[g] = (cmd_addr == ADDR_W'(g)) && (cmd_c != CMD_NOP);
    assign ch_cmd     = sel_vec[g] ? cmd_c : CMD_NOP;

    evmon_chg_det #(.VEC_W(VEC_W)) u_det (
      .clk    (clk),
      .rst    (rst),
      .vec_in (watch_bus[g*VEC_W +: VEC_W]),
      .act    (act_vec[g])
    );

    evmon_cnt_unit #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .cmd_in  (ch_cmd),
      .act     (act_vec[g]),
      .cnt_out (cnt_flat[g*CNT_W +: CNT_W])
    );
  end

  evmon_out_mux #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_mux (
    .clk      (clk),
    .rst      (rst),
    .addr     (cmd_addr),
    .cnt_flat (cnt_flat),
    .mon_q    (mon_out)
  );

  assert_single_target_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_vec));
endmodule

// File: tb/evmon_bank_tb.sv
module evmon_bank_tb;
  localparam int N  = 16;
  localparam int VW = 4;
  localparam int CW = 8;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [1:0]    cmd = 2'b00;
  logic [N*VW-1:0] bus = '0;
  logic [CW-1:0] mon;

  always #5 clk = ~clk;

  evmon_bank #(.NUM_CH(N), .VEC_W(VW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .cmd_addr(addr), .cmd(cmd), .watch_bus(bus), .mon_out(mon)
  );

  logic [VW-1:0] v  [N];
  logic [VW-1:0] pv [N];
  logic [CW-1:0] ec [N];
  int            es [N];
  logic [CW-1:0] emon;
  int checks = 0;
  int errors = 0;

  task automatic chk(input string tag, input logic [CW-1:0] a, input logic [CW-1:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, a, e);
    end
  endtask

  task automatic step(input int a, input int c, input bit r, input string tag);
    @(negedge clk);
    rst = r; addr = AW'(a); cmd = 2'(c);
    for (int ch = 0; ch < N; ch++) bus[ch*VW +: VW] = v[ch];
    @(posedge clk);
    if (r) begin
      emon = '0;
      for (int ch = 0; ch < N; ch++) begin ec[ch] = '0; es[ch] = 0; pv[ch] = '0; end
    end else begin
      emon = ec[a];
      for (int ch = 0; ch < N; ch++) begin
        if (es[ch] == 0) ec[ch] = '0;
        else if (es[ch] == 1 && v[ch] != pv[ch]) ec[ch] = ec[ch] + 1'b1;
        if (ch == a && c != 0) es[ch] = (c == 1) ? 1 : (c == 2) ? 0 : 2;
        pv[ch] = v[ch];
      end
    end
    #1;
    chk(tag, mon, emon);
  endtask

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int ch = 0; ch < N; ch++) begin v[ch] = VW'(ch); pv[ch] = '0; ec[ch] = '0; es[ch] = 0; end
    repeat (3) step(0, 0, 1, "R1 reset");
    // R1: toggling vectors while cleared, read every channel
    for (int ch = 0; ch < N; ch++) begin
      for (int k = 0; k < N; k++) v[k] = ~v[k];
      step(ch, 0, 0, "R1 cleared");
      step(ch, 0, 0, "R1 cleared");
      chk("R1 zero", mon, '0);
    end
    // R2/R6: start channel 3, invert its vector every cycle
    step(3, 1, 0, "R2 start");
    for (int k = 0; k < 10; k++) begin v[3] = ~v[3]; step(3, 0, 0, "R2 run"); end
    step(3, 0, 0, "R6 quiet");
    step(3, 0, 0, "R2 read");
    chk("R2 ten", mon, 8'd10);
    // R6: constant vector adds nothing
    for (int k = 0; k < 5; k++) step(3, 0, 0, "R6 constant");
    chk("R6 constant", mon, 8'd10);
    // R5: other channels untouched, unaddressed commands ignored
    step(4, 0, 0, "R5 other");
    step(4, 0, 0, "R5 other");
    chk("R5 other zero", mon, '0);
    step(7, 1, 0, "R5 start7");
    v[3] = ~v[3]; step(7, 3, 0, "R5 cmd to 7");
    step(3, 0, 0, "R5 read3");
    step(3, 0, 0, "R5 read3");
    chk("R5 ch3 kept counting", mon, 8'd11);
    // R4: freeze channel 3
    step(3, 3, 0, "R4 hold");
    for (int k = 0; k < 6; k++) begin v[3] = ~v[3]; step(3, 0, 0, "R4 frozen"); end
    chk("R4 frozen", mon, 8'd11);
    // R3: clear channel 3
    step(3, 2, 0, "R3 clear");
    for (int k = 0; k < 4; k++) begin v[3] = ~v[3]; step(3, 0, 0, "R3 cleared"); end
    chk("R3 zero", mon, '0);
    // R7: wrap on channel 5
    step(5, 1, 0, "R7 start");
    for (int k = 0; k < 300; k++) begin v[5] = ~v[5]; step(5, 0, 0, "R7 run"); end
    step(5, 3, 0, "R7 hold");
    step(5, 0, 0, "R7 read");
    chk("R7 wrap", mon, 8'd44);
    // R9: reset beats start command in the same cycle
    step(2, 1, 1, "R9 reset+start");
    for (int k = 0; k < 4; k++) begin v[2] = ~v[2]; step(2, 0, 0, "R9 still cleared"); end
    chk("R9 zero", mon, '0);
    // R8: sweep with mixed patterns and commands, compared every cycle
    for (int ch = 0; ch < N; ch++) step(ch, 1, 0, "R8 start all");
    for (int cyc = 0; cyc < 3000; cyc++) begin
      for (int ch = 0; ch < N; ch++)
        if (((cyc + ch) % 3) != 0) v[ch] = VW'(ch * 7 + cyc * cyc);
      step((cyc * 5 + cyc / 16) % N, ((cyc % 7) == 0) ? (cyc / 7) % 4 : 0, 0, "R8 sweep");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule